// File: doc/BRIEF.md
# Burst-Addressed Synchronous Cache Data SRAM

This block is a synchronous static RAM for the data store of a cache. The address, the write data and every control input except the output enable are captured on the rising clock edge. A burst begins on an edge where either of two active-low start strobes is low and the chip enable is low. At that edge the whole external address is loaded. After that, an active-low advance input moves the two low address bits through a wrapping 2-bit count, while the upper address bits stay fixed.

Writes are byte-lane based. A lower and an upper write enable each control one half of the word. A write takes effect at the clock edge and needs no pulse shaping. Read data for the address accessed at an edge appears after that edge and is stable before the next one. An asynchronous output enable gates the read port. When it is high, the valid flag drops and the data bus reads as zero, which models the high-impedance state.

The default depth is kept small so the model elaborates quickly. `ADDR_W` can be raised to 16 to give the full 65,536-word array. The data path has no handshake: every access takes exactly one clock.

Top module: `bsram_burst`

## Requirements
- R1: After reset no burst is active and `rdata_vld_o` is 0.
- R2: On an edge where either start strobe is low and `ce_n_i` is low, the full `addr_i` is loaded. After that edge, with `oe_n_i` low, `rdata_vld_o` is 1 and `rdata_o` shows the word stored at that address.
- R3: On an edge where a start strobe is low and `ce_n_i` is high, the cycle is ignored. No lane is written, no burst is active afterwards, and `rdata_vld_o` stays 0 until a later start.
- R4: In an active burst, an edge with both start strobes high and `adv_n_i` low adds 1 to address bits [1:0], modulo 4 (3 wraps to 0). Bits above bit 1 keep their loaded value.
- R5: In an active burst, an edge with both start strobes high and `adv_n_i` high repeats the current address for the read or write at that edge.
- R6: `we_lo_n_i` low writes bits [8:0] and `we_hi_n_i` low writes bits [17:9] of the accessed word. Each lane is written independently of the other.
- R7: A start with `start_cpu_n_i` low is always a read, even if `start_ctl_n_i` is also low. Both write enables are ignored at that edge.
- R8: Starts by `start_ctl_n_i` alone, and burst continuations, honour the write enables. A read of a just-written address returns the new lanes, including in the cycle right after the writing edge.
- R9: `oe_n_i` acts without a clock. While it is high, `rdata_vld_o` is 0 and `rdata_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the burst control state |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 2*LANE_W | Write data |
| ce_n_i | input | 1 | Chip enable, active low, sampled on start edges |
| start_cpu_n_i | input | 1 | Processor-side start strobe, active low, read only |
| start_ctl_n_i | input | 1 | Controller-side start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| we_lo_n_i | input | 1 | Lower lane write enable, active low |
| we_hi_n_i | input | 1 | Upper lane write enable, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 2*LANE_W | Read data, zero while not valid |
| rdata_vld_o | output | 1 | Read data valid (models the driven bus) |

## Verification
Two functions meet in the same cycle: a lane write on a burst continuation and the read of that same word. A held or advanced continuation with one write enable low is followed by the output sampled after that edge. The output must already show the new lane merged with the other, untouched lane. A second meeting point is the processor strobe and the controller strobe being low together with write enables low. This is judged by reading the word back later and confirming it did not change.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int unsigned BURST_BITS = 2;
  localparam int unsigned LANES      = 2;

  typedef struct packed {
    logic go;     // start accepted at this edge
    logic cont;   // continuation of an active burst
    logic wr_ok;  // write enables may act at this edge
  } bsram_cmd_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              start_cpu_n_i,
  input  logic              start_ctl_n_i,
  input  logic              adv_n_i,
  output bsram_cmd_t        cmd_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              act_o
);
  logic                  start;
  logic [BURST_BITS-1:0] low_step;
  logic [ADDR_W-1:0]     cur_q;
  logic                  act_q;

  assign start    = ~start_cpu_n_i | ~start_ctl_n_i;
  assign low_step = cur_q[BURST_BITS-1:0] + 1'b1;

  always_comb begin
    cmd_o.go    = start & ~ce_n_i;
    cmd_o.cont  = ~start & act_q;
    // processor-side start is a read; it wins when both strobes are low
    cmd_o.wr_ok = (cmd_o.go & start_cpu_n_i) | cmd_o.cont;
    acc_addr_o  = cur_q;
    if (cmd_o.go)
      acc_addr_o = addr_i;
    else if (cmd_o.cont && !adv_n_i)
      acc_addr_o = {cur_q[ADDR_W-1:BURST_BITS], low_step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cur_q <= '0;
    end else begin
      if (start) act_q <= cmd_o.go;
      cur_q <= acc_addr_o;
    end
  end

  assign cur_addr_o = cur_q;
  assign act_o      = act_q;
endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned NLANE  = 2,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned WORD_W = LANE_W * NLANE
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NLANE-1:0]  wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en_i[g]) mem[wr_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[rd_addr_i];
  end
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ce_n_i,
  input  logic              start_cpu_n_i,
  input  logic              start_ctl_n_i,
  input  logic              adv_n_i,
  input  logic              we_lo_n_i,
  input  logic              we_hi_n_i,
  input  logic              oe_n_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_vld_o
);
  bsram_cmd_t        cmd;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic              burst_act;
  logic [LANES-1:0]  lane_wr;
  logic [WORD_W-1:0] word;

  bsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .ce_n_i       (ce_n_i),
    .start_cpu_n_i(start_cpu_n_i),
    .start_ctl_n_i(start_ctl_n_i),
    .adv_n_i      (adv_n_i),
    .cmd_o        (cmd),
    .acc_addr_o   (acc_addr),
    .cur_addr_o   (cur_addr),
    .act_o        (burst_act)
  );

  assign lane_wr[0] = (cmd.go | cmd.cont) & cmd.wr_ok & ~we_lo_n_i;
  assign lane_wr[1] = (cmd.go | cmd.cont) & cmd.wr_ok & ~we_hi_n_i;

  bsram_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NLANE(LANES)) u_lanes (
    .clk      (clk),
    .wr_addr_i(acc_addr),
    .wr_en_i  (lane_wr),
    .wdata_i  (wdata_i),
    .rd_addr_i(cur_addr),
    .rdata_o  (word)
  );

  assign rdata_vld_o = burst_act & ~oe_n_i;
  assign rdata_o     = rdata_vld_o ? word : '0;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce_n_i,
  input logic              start_cpu_n_i,
  input logic              start_ctl_n_i,
  input logic              adv_n_i,
  input logic              oe_n_i,
  input logic              rdata_vld_o,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              burst_act
);
  logic no_start;
  assign no_start = start_cpu_n_i & start_ctl_n_i;

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_start && !ce_n_i) |=> (burst_act && cur_addr == $past(addr_i)));

  assert_ce_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_start && ce_n_i) |=> !burst_act);

  assert_adv_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_act && no_start && !adv_n_i) |=>
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    no_start |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (no_start && adv_n_i) |=> $stable(cur_addr));

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !rdata_vld_o);
endmodule

bind bsram_burst bsram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_i       (addr_i),
  .ce_n_i       (ce_n_i),
  .start_cpu_n_i(start_cpu_n_i),
  .start_ctl_n_i(start_ctl_n_i),
  .adv_n_i      (adv_n_i),
  .oe_n_i       (oe_n_i),
  .rdata_vld_o  (rdata_vld_o),
  .cur_addr     (cur_addr),
  .burst_act    (burst_act)
);

// File: tb/sim_bsram_burst.sv
`timescale 1ns/1ps
module sim_bsram_burst;
  localparam int AW = 10;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ce_n = 1'b1, cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic wlo_n = 1'b1, whi_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] rdata;
  logic          rvld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          m_act = 1'b0;
  logic [AW-1:0] m_cur = '0;
  logic [DW-1:0] m_mem [1 << AW];

  logic          vq[$];
  logic [DW-1:0] dq[$];
  string         tq[$];

  always #10 clk = ~clk;

  bsram_burst u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .ce_n_i(ce_n), .start_cpu_n_i(cpu_n), .start_ctl_n_i(ctl_n),
    .adv_n_i(adv_n), .we_lo_n_i(wlo_n), .we_hi_n_i(whi_n),
    .oe_n_i(oe_n), .rdata_o(rdata), .rdata_vld_o(rvld)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one edge, update the model, push expectation
  task automatic cyc(input logic c_cpu, input logic c_ctl, input logic c_ce,
                     input logic c_adv, input logic c_wlo, input logic c_whi,
                     input logic c_oe, input logic [AW-1:0] c_addr,
                     input logic [DW-1:0] c_wd, input string tag);
    logic start, wr_ok, access;
    cpu_n = c_cpu; ctl_n = c_ctl; ce_n = c_ce; adv_n = c_adv;
    wlo_n = c_wlo; whi_n = c_whi; oe_n = c_oe; addr = c_addr; wdata = c_wd;
    start = !c_cpu || !c_ctl;
    wr_ok = 1'b0;
    access = 1'b0;
    if (start) begin
      m_act = !c_ce;
      if (!c_ce) begin
        m_cur = c_addr;
        access = 1'b1;
        wr_ok = c_cpu;
      end
    end else if (m_act) begin
      access = 1'b1;
      wr_ok = 1'b1;
      if (!c_adv) m_cur = {m_cur[AW-1:2], m_cur[1:0] + 2'd1};
    end
    if (access && wr_ok && !c_wlo) m_mem[m_cur][8:0]  = c_wd[8:0];
    if (access && wr_ok && !c_whi) m_mem[m_cur][17:9] = c_wd[17:9];
    vq.push_back(m_act && !c_oe);
    dq.push_back((m_act && !c_oe) ? m_mem[m_cur] : '0);
    tq.push_back(tag);
    @(posedge clk);
    #15;
  endtask

  // monitor: compare outputs after each edge
  always @(negedge clk) begin
    if (vq.size() > 0) begin
      logic          ev;
      logic [DW-1:0] ed;
      string         et;
      ev = vq.pop_front();
      ed = dq.pop_front();
      et = tq.pop_front();
      check(rvld === ev && rdata === ed, et, {rvld, rdata}, {ev, ed});
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    #10;
    check(rvld === 1'b0, "R1 reset valid", {18'h0, rvld}, 19'h0);
    @(posedge clk); #15;

    // R8 controller start writes, R4 continuation writes
    cyc(1,0,0,1,0,0,0, 10'h010, 18'h1A001, "R8 ctl start write");
    cyc(1,1,0,0,0,0,0, 10'h000, 18'h1A002, "R4 adv write 0x11");
    cyc(1,1,0,0,0,0,0, 10'h000, 18'h1A003, "R4 adv write 0x12");
    cyc(1,1,0,0,0,0,0, 10'h000, 18'h1A004, "R4 adv write 0x13");
    // R7 processor start ignores write enables
    cyc(0,1,0,1,0,0,0, 10'h010, 18'h3FFFF, "R7 cpu start read");
    cyc(1,1,0,0,1,1,0, 10'h000, 18'h0, "R4 adv read 0x11");
    cyc(1,1,0,0,1,1,0, 10'h000, 18'h0, "R4 adv read 0x12");
    cyc(1,1,0,0,1,1,0, 10'h000, 18'h0, "R4 adv read 0x13");
    cyc(1,1,0,0,1,1,0, 10'h000, 18'h0, "R4 wrap to 0x10");
    cyc(1,1,0,1,1,1,0, 10'h000, 18'h0, "R5 hold repeat");
    // R2 start at low bits 2, R4 wrap keeps upper bits
    cyc(1,0,0,1,1,1,0, 10'h012, 18'h0, "R2 load 0x12");
    cyc(1,1,0,0,1,1,0, 10'h3FF, 18'h0, "R4 step 0x13");
    cyc(1,1,0,0,1,1,0, 10'h3FF, 18'h0, "R4 wrap upper fixed");
    // R6 lane writes, merged read in the next cycle (R8)
    cyc(1,0,0,1,0,0,0, 10'h020, 18'h2AAAA, "R6 full word");
    cyc(1,0,0,1,0,1,0, 10'h020, 18'h15555, "R6 lower lane only");
    cyc(1,1,0,1,1,1,0, 10'h000, 18'h0, "R6 lower merged");
    cyc(1,1,0,1,1,0,0, 10'h000, 18'h00000, "R6 upper lane only");
    cyc(1,1,0,1,1,1,0, 10'h000, 18'h0, "R8 read after write");
    // R3 chip enable high on a start edge
    cyc(1,0,1,1,0,0,0, 10'h010, 18'h00000, "R3 ignored start");
    cyc(1,1,0,0,0,0,0, 10'h000, 18'h00000, "R3 no burst after");
    cyc(0,1,0,1,1,1,0, 10'h010, 18'h0, "R3 data unchanged");
    // R7 both strobes low with write enables
    cyc(0,0,0,1,0,0,0, 10'h011, 18'h00000, "R7 both strobes read");
    cyc(0,1,0,1,1,1,0, 10'h011, 18'h0, "R7 data unchanged");
    // R9 output enable
    cyc(0,1,0,1,1,1,1, 10'h012, 18'h0, "R9 oe high masks");
    cyc(1,1,0,1,1,1,0, 10'h000, 18'h0, "R9 oe low shows");
    #1 oe_n = 1'b1;
    #1 check(rvld === 1'b0 && rdata === '0, "R9 async off", {rvld, rdata}, 19'h0);
    oe_n = 1'b0;
    #1 check(rvld === 1'b1 && rdata === 18'h1A003, "R9 async on",
             {rvld, rdata}, {1'b1, 18'h1A003});
    @(posedge clk); #15;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule